// File: doc/BRIEF.md
# Chip-Select Gated Dual-Bank Command Register

This block is a registered address and command buffer for a memory module. On every rising clock edge it samples a 28-position input bus and drives the registered value onto two identical output banks, A and B. Most positions carry address and command data. Six positions carry side-band signals: a pair of clock-enable lines, a pair of termination-control lines, and a pair of chip selects.

A static map-select input decides which six positions carry the side-band signals. A gate-enable input can save power: when it is set, the data positions update only on edges where a chip select is asserted (low). On all other edges they hold their value. The side-band positions are never gated. An asynchronous active-low reset clears every register at once and overrides all other control.

Top module: `rcd_dual_register`

## Requirements
- R1: When `gate_en` is low, every data position of both banks takes the value sampled at each rising edge.
- R2: When `gate_en` is high, the data positions take the sampled value on an edge where at least one of the two chip selects is low.
- R3: When `gate_en` is high and both chip selects are high at the edge, every data position keeps its previous value.
- R4: The clock-enable and termination positions take the sampled value on every edge, whatever the state of `gate_en` or the chip selects.
- R5: The two chip-select positions are registered and re-driven on every edge, and they are never held by the gating.
- R6: Driving `rst_n` low clears both banks to zero at once, with no clock edge needed. The banks stay zero at clock edges for as long as `rst_n` is low, whatever the inputs are.
- R7: With `map_sel` low, position index = `d_in` bit + 1. In this map, positions 6 and 8 are clock-enable, 15 and 16 are termination, and 14 and 13 are chip selects 0 and 1. All other positions are data.
- R8: With `map_sel` high, positions 21 and 23 are clock-enable, 13 and 14 are termination, and 15 and 16 are chip selects 0 and 1. All other positions are data.
- R9: Bank B always carries the same value as bank A.
- R10: After `rst_n` rises, both banks stay zero until the next rising edge. That edge loads the sampled inputs under the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Static choice of side-band position map (0 or 1) |
| gate_en | input | 1 | Chip-select gating of the data positions when high |
| d_in | input | 28 | Input bus, bit i is position i+1 |
| q_a | output | 28 | Registered bank A |
| q_b | output | 28 | Registered bank B |

## Verification
The bench sweeps all eight combinations of gate enable and the two chip selects, with pseudo-random data, under both position maps. A design that decoded the chip selects from the wrong positions would hold or update data on the wrong edges. A design that applied the gate to the side-band positions would freeze clock-enable, termination or chip-select outputs while both selects are high. Reset is asserted between clock edges and with all-ones inputs present. This exposes a synchronous reset, which would leave the outputs non-zero until an edge, and a reset that loses priority to the data. The first edge after release is checked so that a missed or doubled capture shows up.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    localparam int NUM_POS = 28;

    typedef enum logic [1:0] {
        ROLE_DATA = 2'd0,
        ROLE_CKE  = 2'd1,
        ROLE_ODT  = 2'd2,
        ROLE_CS   = 2'd3
    } role_e;

    // zero-based bit indices, map 0
    localparam int M0_CKE_LO = 5;
    localparam int M0_CKE_HI = 7;
    localparam int M0_ODT_LO = 14;
    localparam int M0_ODT_HI = 15;
    localparam int M0_CS0    = 13;
    localparam int M0_CS1    = 12;
    // zero-based bit indices, map 1
    localparam int M1_CKE_LO = 20;
    localparam int M1_CKE_HI = 22;
    localparam int M1_ODT_LO = 12;
    localparam int M1_ODT_HI = 13;
    localparam int M1_CS0    = 14;
    localparam int M1_CS1    = 15;

    function automatic role_e role_of(input int idx, input logic map_b);
        role_e r;
        r = ROLE_DATA;
        if (!map_b) begin
            if (idx == M0_CKE_LO || idx == M0_CKE_HI)      r = ROLE_CKE;
            else if (idx == M0_ODT_LO || idx == M0_ODT_HI) r = ROLE_ODT;
            else if (idx == M0_CS0 || idx == M0_CS1)       r = ROLE_CS;
        end else begin
            if (idx == M1_CKE_LO || idx == M1_CKE_HI)      r = ROLE_CKE;
            else if (idx == M1_ODT_LO || idx == M1_ODT_HI) r = ROLE_ODT;
            else if (idx == M1_CS0 || idx == M1_CS1)       r = ROLE_CS;
        end
        return r;
    endfunction

endpackage

// File: rtl/rcd_role_decode.sv
module rcd_role_decode #(
    parameter int NPOS = rcd_pkg::NUM_POS
) (
    input  logic                         map_sel,
    output rcd_pkg::role_e [NPOS-1:0]    role_vec
);
    for (genvar i = 0; i < NPOS; i++) begin : g_role
        assign role_vec[i] = rcd_pkg::role_of(i, map_sel);
    end
endmodule

// File: rtl/rcd_gate_ctrl.sv
module rcd_gate_ctrl (
    input  logic       map_sel,
    input  logic       gate_en,
    input  logic [1:0] cs_map0,   // {cs1, cs0} as seen under map 0
    input  logic [1:0] cs_map1,   // {cs1, cs0} as seen under map 1
    output logic       capture_data
);
    logic [1:0] cs_sel;

    always_comb begin
        cs_sel       = map_sel ? cs_map1 : cs_map0;
        capture_data = !gate_en || !cs_sel[0] || !cs_sel[1];
    end
endmodule

// File: rtl/rcd_bit_reg.sv
module rcd_bit_reg (
    input  logic           clk,
    input  logic           rst_n,
    input  rcd_pkg::role_e role,
    input  logic           capture_data,
    input  logic           d,
    output logic           q_a,
    output logic           q_b
);
    import rcd_pkg::*;

    logic load;

    always_comb load = (role != ROLE_DATA) || capture_data;

    // two independent flops, one per output bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_a <= 1'b0;
        else if (load) q_a <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_b <= 1'b0;
        else if (load) q_b <= d;
    end

    // R1 / R2: a data bit loads when the gate controller allows it
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_DATA && capture_data) |=> (q_a == $past(d)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_DATA && !capture_data) |=> $stable(q_a));

    // R4 / R5: side-band bits are never gated
    a_r4_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        (role != ROLE_DATA) |=> (q_a == $past(d)));

    a_r9_banks: assert property (@(posedge clk) disable iff (!rst_n)
        q_a == q_b);
endmodule

// File: rtl/rcd_dual_register.sv
module rcd_dual_register #(
    parameter int NPOS = rcd_pkg::NUM_POS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            map_sel,
    input  logic            gate_en,
    input  logic [NPOS-1:0] d_in,
    output logic [NPOS-1:0] q_a,
    output logic [NPOS-1:0] q_b
);
    import rcd_pkg::*;

    role_e [NPOS-1:0] role_vec;
    logic             capture_data;

    rcd_role_decode #(.NPOS(NPOS)) u_roles (
        .map_sel  (map_sel),
        .role_vec (role_vec)
    );

    rcd_gate_ctrl u_gate (
        .map_sel      (map_sel),
        .gate_en      (gate_en),
        .cs_map0      ({d_in[M0_CS1], d_in[M0_CS0]}),
        .cs_map1      ({d_in[M1_CS1], d_in[M1_CS0]}),
        .capture_data (capture_data)
    );

    for (genvar i = 0; i < NPOS; i++) begin : g_bit
        rcd_bit_reg u_bit (
            .clk          (clk),
            .rst_n        (rst_n),
            .role         (role_vec[i]),
            .capture_data (capture_data),
            .d            (d_in[i]),
            .q_a          (q_a[i]),
            .q_b          (q_b[i])
        );
    end

    // R6: outputs are zero at any edge seen while reset is held
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0));

    // R10: nothing leaves zero between release and the first edge
    a_r10_release_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (q_a == '0 && q_b == '0));
endmodule

// File: tb/tb_rcd_dual_register.sv
module tb_rcd_dual_register;
    localparam int CLK_PERIOD = 10;
    localparam int N = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         map_sel = 1'b0;
    logic         gate_en = 1'b0;
    logic [N-1:0] d_in = '0;
    logic [N-1:0] q_a;
    logic [N-1:0] q_b;

    int           errors = 0;
    int           checks = 0;
    logic [N-1:0] exp_q = '0;
    logic [31:0]  lfsr = 32'hACE1_1234;
    localparam logic [N-1:0] ALL = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcd_dual_register dut (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .gate_en(gate_en),
        .d_in(d_in), .q_a(q_a), .q_b(q_b)
    );

    // role codes: 0 data, 1 clock-enable, 2 termination, 3 chip select
    function automatic int role_b(int i, logic mb);
        if (!mb) begin
            if (i == 5 || i == 7)   return 1;
            if (i == 14 || i == 15) return 2;
            if (i == 12 || i == 13) return 3;
        end else begin
            if (i == 20 || i == 22) return 1;
            if (i == 12 || i == 13) return 2;
            if (i == 14 || i == 15) return 3;
        end
        return 0;
    endfunction

    function automatic logic [N-1:0] mask_of(int r, logic mb);
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++) if (role_b(i, mb) == r) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] expv, input logic [N-1:0] m);
        checks++;
        if ((got & m) !== (expv & m)) begin
            errors++;
            $display("FAIL %s: got %h expected %h (mask %h)", tag, got & m, expv & m, m);
        end
    endtask

    // called at a falling edge; drives inputs, checks after the next rising edge
    task automatic step(input logic g, input logic [N-1:0] d,
                        input logic cs0v, input logic cs1v);
        logic [N-1:0] dv;
        logic cap;
        string tag;
        string mt;
        dv = d;
        dv[map_sel ? 14 : 13] = cs0v;
        dv[map_sel ? 15 : 12] = cs1v;
        gate_en = g;
        d_in = dv;
        cap = !g || !cs0v || !cs1v;
        for (int i = 0; i < N; i++)
            if (role_b(i, map_sel) != 0 || cap) exp_q[i] = dv[i];
        @(negedge clk);
        tag = !g ? "R1" : (cap ? "R2" : "R3");
        mt = map_sel ? "R8" : "R7";
        chk({tag, " data ", mt}, q_a, exp_q, mask_of(0, map_sel));
        chk({"R4 cke/odt ", mt}, q_a, exp_q, mask_of(1, map_sel) | mask_of(2, map_sel));
        chk({"R5 chip select ", mt}, q_a, exp_q, mask_of(3, map_sel));
        chk("R9 bank B", q_b, exp_q, ALL);
    endtask

    task automatic run_map(input logic mb);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 async clear", q_a, '0, ALL);
        chk("R6 async clear bank B", q_b, '0, ALL);
        map_sel = mb;
        gate_en = 1'b0;
        d_in = ALL;
        exp_q = '0;
        @(negedge clk);
        chk("R6 held through edge", q_a, '0, ALL);
        chk("R6 held through edge bank B", q_b, '0, ALL);
        // release between edges with live inputs
        d_in = 28'h5A3C96F;
        rst_n = 1'b1;
        #1;
        chk("R10 quiet after release", q_a, '0, ALL);
        @(negedge clk);
        chk("R10 first edge loads", q_a, 28'h5A3C96F, ALL);
        exp_q = 28'h5A3C96F;
        step(1'b0, ALL, 1'b1, 1'b1);
        step(1'b1, '0, 1'b1, 1'b1);
        step(1'b1, '0, 1'b0, 1'b1);
        step(1'b1, ALL, 1'b1, 1'b0);
        step(1'b1, '0, 1'b1, 1'b1);
        for (int rep = 0; rep < 24; rep++) begin
            for (int c = 0; c < 8; c++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                step(c[2], lfsr[N-1:0], c[1], c[0]);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        #1;
        rst_n = 1'b0;
        #1;
        chk("R6 clear at start", q_a, '0, ALL);
        run_map(1'b0);
        run_map(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R6 final async clear", q_a, '0, ALL);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule